// File: doc/BRIEF.md
# Hash Unit Interrupt Merger

This block gathers event pulses from a hash engine and from the DMA engine that feeds it. It keeps them as sticky status bits in two banks and merges them into one level-sensitive interrupt line. Each bank has a status register and an enable register. Software clears status bits by writing ones to the status register. The DMA bank also has a one-bit unmask register, and no DMA status reaches the output until that bit is set.

Besides the merged interrupt, the block drives two summary lines. One reports that an enabled error condition is pending and the other that an enabled completion condition is pending. A driver can therefore tell a failed job from a finished one without reading either status register. Registers sit on a 32-bit bus with a single-cycle write strobe and combinational read data.

Top module: `hash_irq_merge`

## Requirements
- R1: After a synchronous reset, every status, enable and unmask bit is zero, `irq_o`, `err_o` and `done_o` are low, and all five registers read as zero.
- R2: A one on `core_evt[i]` at a rising edge sets hash status bit i (address 0x050). The bit stays set until software clears it. Bit 2 is completion; bits 0, 1 and 3 are errors.
- R3: A one on `dma_evt[i]` sets DMA status bit i (address 0x480). Bit 0 is completion and bits 2 to 8 are errors. Bit 1 is unimplemented and always reads 0.
- R4: A write to a status address clears exactly the status bits whose write-data bit is one. Writing 0xFFFFFFFF clears the whole bank.
- R5: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: The hash enable register (0x054) and the DMA enable register (0x484) read back the implemented bits that were written, 0x0F and 0x1FD respectively. A bank whose enable is zero cannot raise any output, and its status bits are kept.
- R7: The DMA bank affects the outputs only while bit 0 of the unmask register (0x488) is one. The unmask register reads back only bit 0.
- R8: `irq_o` is high exactly when hash status AND hash enable is nonzero, or when the unmask bit is set and DMA status AND DMA enable is nonzero. It changes in the cycle after the register update that causes it.
- R9: `err_o` is high when any enabled error bit is pending (DMA errors only while unmasked), whether or not a completion bit is also pending.
- R10: `done_o` is high when an enabled completion bit is pending (hash bit 2, or DMA bit 0 while unmasked).
- R11: Writes to any other address change no state, and reads of any other address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| core_evt | input | 4 | Hash engine event pulses |
| dma_evt | input | 9 | DMA engine event pulses |
| irq_o | output | 1 | Merged level interrupt |
| err_o | output | 1 | Enabled error pending |
| done_o | output | 1 | Enabled completion pending |

## Verification
A status bit that was lost or dropped early shows up one cycle after its event. The interrupt and summary lines fail to rise, or fall while nothing cleared them, and a read of the status address returns the wrong pattern. A wrong enable or unmask state shows on the next output sample after the register write. A faulty clear or priority path appears as a status read that differs right after the write cycle. Error and completion are kept on separate lines, so a misclassified bit is seen on the first cycle it is pending.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

    localparam int DW       = 32;
    localparam int AW       = 12;
    localparam int HASH_W   = 4;
    localparam int DMA_W    = 9;

    // Register map; the addresses are the decode software relies on.
    localparam logic [AW-1:0] A_HASH_ST = 12'h050;
    localparam logic [AW-1:0] A_HASH_EN = 12'h054;
    localparam logic [AW-1:0] A_DMA_ST  = 12'h480;
    localparam logic [AW-1:0] A_DMA_EN  = 12'h484;
    localparam logic [AW-1:0] A_DMA_UM  = 12'h488;

    // Bit classes per bank.
    localparam logic [HASH_W-1:0] HASH_IMPL = 4'b1111;
    localparam logic [HASH_W-1:0] HASH_ERR  = 4'b1011;
    localparam logic [HASH_W-1:0] HASH_DONE = 4'b0100;
    localparam logic [DMA_W-1:0]  DMA_IMPL  = 9'h1FD;
    localparam logic [DMA_W-1:0]  DMA_ERR   = 9'h1FC;
    localparam logic [DMA_W-1:0]  DMA_DONE  = 9'h001;

    // Per-bank summary carried to the merge stage.
    typedef struct packed {
        logic err;
        logic done;
    } bank_sum_t;

    function automatic logic [DW-1:0] zext_hash(input logic [HASH_W-1:0] v);
        return {{(DW-HASH_W){1'b0}}, v};
    endfunction

    function automatic logic [DW-1:0] zext_dma(input logic [DMA_W-1:0] v);
        return {{(DW-DMA_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/hirq_bank.sv
module hirq_bank
    import hirq_pkg::*;
#(
    parameter int            W       = 4,
    parameter logic [W-1:0]  IMPL    = '1,
    parameter logic [W-1:0]  ERRM    = '0,
    parameter logic [W-1:0]  DONEM   = '0,
    parameter logic [AW-1:0] ST_ADDR = '0,
    parameter logic [AW-1:0] EN_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  evt,
    output logic [W-1:0]  stat,
    output logic [W-1:0]  en,
    output bank_sum_t     sum
);

    logic st_hit;
    logic en_hit;

    assign st_hit = wr && (addr == ST_ADDR);
    assign en_hit = wr && (addr == EN_ADDR);

    // One sticky flop per implemented bit; set beats clear.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_flop
            always_ff @(posedge clk) begin
                if (rst)
                    stat[i] <= 1'b0;
                else if (evt[i])
                    stat[i] <= 1'b1;
                else if (st_hit && wdata[i])
                    stat[i] <= 1'b0;
            end
        end else begin : g_tie
            assign stat[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            en <= '0;
        else if (en_hit)
            en <= wdata & IMPL;
    end

    logic [W-1:0] live;
    assign live     = stat & en;
    assign sum.err  = |(live & ERRM);
    assign sum.done = |(live & DONEM);

endmodule

// File: rtl/hirq_merge.sv
module hirq_merge
    import hirq_pkg::*;
(
    input  bank_sum_t hash_sum,
    input  bank_sum_t dma_sum,
    input  logic      unmask,
    output logic      irq_o,
    output logic      err_o,
    output logic      done_o
);

    bank_sum_t dma_gated;

    assign dma_gated.err  = dma_sum.err  & unmask;
    assign dma_gated.done = dma_sum.done & unmask;

    assign err_o  = hash_sum.err  | dma_gated.err;
    assign done_o = hash_sum.done | dma_gated.done;
    assign irq_o  = err_o | done_o;

endmodule

// File: rtl/hash_irq_merge.sv
module hash_irq_merge
    import hirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [11:0]   reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic [3:0]    core_evt,
    input  logic [8:0]    dma_evt,
    output logic          irq_o,
    output logic          err_o,
    output logic          done_o
);

    logic [HASH_W-1:0] hash_stat, hash_en;
    logic [DMA_W-1:0]  dma_stat, dma_en;
    logic              unmask;
    bank_sum_t         hash_sum, dma_sum;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^reg_wdata[DW-1:DMA_W];

    hirq_bank #(
        .W(HASH_W), .IMPL(HASH_IMPL), .ERRM(HASH_ERR), .DONEM(HASH_DONE),
        .ST_ADDR(A_HASH_ST), .EN_ADDR(A_HASH_EN)
    ) i_hash_bank (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata[HASH_W-1:0]), .evt(core_evt),
        .stat(hash_stat), .en(hash_en), .sum(hash_sum)
    );

    hirq_bank #(
        .W(DMA_W), .IMPL(DMA_IMPL), .ERRM(DMA_ERR), .DONEM(DMA_DONE),
        .ST_ADDR(A_DMA_ST), .EN_ADDR(A_DMA_EN)
    ) i_dma_bank (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata[DMA_W-1:0]), .evt(dma_evt),
        .stat(dma_stat), .en(dma_en), .sum(dma_sum)
    );

    always_ff @(posedge clk) begin
        if (rst)
            unmask <= 1'b0;
        else if (reg_wr && reg_addr == A_DMA_UM)
            unmask <= reg_wdata[0];
    end

    always_comb begin
        unique case (reg_addr)
            A_HASH_ST: reg_rdata = zext_hash(hash_stat);
            A_HASH_EN: reg_rdata = zext_hash(hash_en);
            A_DMA_ST:  reg_rdata = zext_dma(dma_stat);
            A_DMA_EN:  reg_rdata = zext_dma(dma_en);
            A_DMA_UM:  reg_rdata = {{(DW-1){1'b0}}, unmask};
            default:   reg_rdata = '0;
        endcase
    end

    hirq_merge i_merge (
        .hash_sum(hash_sum), .dma_sum(dma_sum), .unmask(unmask),
        .irq_o(irq_o), .err_o(err_o), .done_o(done_o)
    );

endmodule

// File: rtl/hirq_chk.sv
module hirq_chk
    import hirq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [AW-1:0]     reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic [HASH_W-1:0] core_evt,
    input logic [DMA_W-1:0]  dma_evt,
    input logic [HASH_W-1:0] hstat,
    input logic [HASH_W-1:0] hen,
    input logic [DMA_W-1:0]  dstat,
    input logic [DMA_W-1:0]  den,
    input logic              unmask,
    input logic              irq_o,
    input logic              err_o,
    input logic              done_o
);

    // R2: hash status holds while no write targets it
    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == A_HASH_ST) |=> ((hstat & $past(hstat)) == $past(hstat)));

    // R3: DMA events land in the implemented bits
    a_r3_dma_set: assert property (@(posedge clk) disable iff (rst)
        |(dma_evt & DMA_IMPL) |=> ((dstat & $past(dma_evt & DMA_IMPL)) == $past(dma_evt & DMA_IMPL)));

    // R4: a clearing write with no events removes exactly the written ones
    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_HASH_ST && core_evt == '0)
        |=> (hstat == ($past(hstat) & ~$past(reg_wdata[HASH_W-1:0]))));

    // R5: events win against a same-cycle clear
    a_r5_event_wins: assert property (@(posedge clk) disable iff (rst)
        |core_evt |=> ((hstat & $past(core_evt)) == $past(core_evt)));

    // R6: with both banks disabled nothing is raised
    a_r6_disabled: assert property (@(posedge clk) disable iff (rst)
        (hen == '0 && den == '0) |-> !irq_o);

    // R7: masked DMA bank plus idle hash bank keeps the line low
    a_r7_masked: assert property (@(posedge clk) disable iff (rst)
        (!unmask && (hstat & hen) == '0) |-> !irq_o);

    // R8: the line is high only with a pending cause
    a_r8_irq_cause: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (err_o || done_o));

    // R9: an error summary always reaches the line
    a_r9_err_irq: assert property (@(posedge clk) disable iff (rst)
        err_o |-> irq_o);

    // R10: a done summary always reaches the line
    a_r10_done_irq: assert property (@(posedge clk) disable iff (rst)
        done_o |-> irq_o);

endmodule

bind hash_irq_merge hirq_chk i_hirq_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .core_evt(core_evt), .dma_evt(dma_evt),
    .hstat(hash_stat), .hen(hash_en), .dstat(dma_stat), .den(dma_en),
    .unmask(unmask), .irq_o(irq_o), .err_o(err_o), .done_o(done_o)
);

// File: tb/test_hash_irq_merge.sv
module test_hash_irq_merge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  core_evt = '0;
    logic [8:0]  dma_evt = '0;
    logic        irq_o, err_o, done_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hash_irq_merge i_hash_irq_merge (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_evt(core_evt),
        .dma_evt(dma_evt), .irq_o(irq_o), .err_o(err_o), .done_o(done_o)
    );

    typedef struct packed {
        logic [3:0]  ce;
        logic [8:0]  de;
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wd;
        logic [2:0]  exp;   // {irq, err, done}
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{4'h0, 9'h000, 1'b1, 12'h054, 32'h0000000F, 3'b000}, // R6 enable hash
        '{4'h4, 9'h000, 1'b0, 12'h000, 32'h0,        3'b101}, // R10 hash done
        '{4'h0, 9'h000, 1'b1, 12'h050, 32'h00000004, 3'b000}, // R4 clear done
        '{4'h8, 9'h000, 1'b0, 12'h000, 32'h0,        3'b110}, // R9 hash error bit 3
        '{4'h4, 9'h000, 1'b0, 12'h000, 32'h0,        3'b111}, // R9 error with done
        '{4'h0, 9'h000, 1'b1, 12'h050, 32'hFFFFFFFF, 3'b000}, // R4 clear all
        '{4'h0, 9'h004, 1'b0, 12'h000, 32'h0,        3'b000}, // R6 DMA disabled
        '{4'h0, 9'h000, 1'b1, 12'h484, 32'h000001FD, 3'b000}, // R7 still masked
        '{4'h0, 9'h000, 1'b1, 12'h488, 32'h00000001, 3'b110}, // R7 unmask
        '{4'h0, 9'h000, 1'b1, 12'h480, 32'h00000004, 3'b000}, // R4 DMA clear
        '{4'h0, 9'h001, 1'b0, 12'h000, 32'h0,        3'b101}, // R10 DMA done
        '{4'h0, 9'h000, 1'b1, 12'h488, 32'h00000000, 3'b000}, // R7 mask again
        '{4'h0, 9'h000, 1'b1, 12'h488, 32'h00000001, 3'b101}, // R7 unmask again
        '{4'h0, 9'h000, 1'b1, 12'h480, 32'hFFFFFFFF, 3'b000}, // R4 DMA clear all
        '{4'h1, 9'h000, 1'b0, 12'h000, 32'h0,        3'b110}, // R9 hash error bit 0
        '{4'h0, 9'h000, 1'b1, 12'h054, 32'h00000000, 3'b000}, // R6 bank off, kept
        '{4'h0, 9'h000, 1'b1, 12'h054, 32'h0000000F, 3'b110}, // R6 bank back on
        '{4'h0, 9'h000, 1'b1, 12'h050, 32'hFFFFFFFF, 3'b000}  // R8 all quiet
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic [3:0] ce, input logic [8:0] de, input logic wr,
                         input logic [11:0] a, input logic [31:0] wd);
        @(negedge clk);
        core_evt = ce; dma_evt = de; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        @(negedge clk);
        core_evt = '0; dma_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] outs();
        return {29'd0, irq_o, err_o, done_o};
    endfunction

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        check("R1 outputs", outs(), 32'h0);
        rd(12'h050, d); check("R1 hash status", d, 32'h0);
        rd(12'h054, d); check("R1 hash enable", d, 32'h0);
        rd(12'h480, d); check("R1 dma status", d, 32'h0);
        rd(12'h484, d); check("R1 dma enable", d, 32'h0);
        rd(12'h488, d); check("R1 unmask", d, 32'h0);

        // R8 R9 R10: vector walk
        for (int k = 0; k < NV; k++) begin
            cycle(VECS[k].ce, VECS[k].de, VECS[k].wr, VECS[k].addr, VECS[k].wd);
            check($sformatf("R8 R9 R10 vector %0d", k), outs(), {29'd0, VECS[k].exp});
        end

        // R2: sticky across idle cycles
        cycle(4'h2, 9'h0, 1'b0, 12'h0, 32'h0);
        repeat (5) @(negedge clk);
        rd(12'h050, d); check("R2 sticky", d, 32'h2);

        // R5: event beats same-cycle clear; other bits still cleared
        cycle(4'h8, 9'h0, 1'b0, 12'h0, 32'h0);
        cycle(4'h2, 9'h0, 1'b1, 12'h050, 32'hFFFFFFFF);
        rd(12'h050, d); check("R5 event wins", d, 32'h2);
        cycle(4'h0, 9'h0, 1'b1, 12'h050, 32'hFFFFFFFF);

        // R3: reserved DMA bit never sets
        cycle(4'h0, 9'h1FF, 1'b0, 12'h0, 32'h0);
        rd(12'h480, d); check("R3 dma status", d, 32'h1FD);
        cycle(4'h0, 9'h0, 1'b1, 12'h480, 32'h00000104);
        rd(12'h480, d); check("R4 partial clear", d, 32'h0F9);

        // R6 / R7: readback widths
        cycle(4'h0, 9'h0, 1'b1, 12'h054, 32'hFFFFFFFF);
        rd(12'h054, d); check("R6 hash enable readback", d, 32'hF);
        cycle(4'h0, 9'h0, 1'b1, 12'h484, 32'hFFFFFFFF);
        rd(12'h484, d); check("R6 dma enable readback", d, 32'h1FD);
        cycle(4'h0, 9'h0, 1'b1, 12'h488, 32'hFFFFFFFE);
        rd(12'h488, d); check("R7 unmask bit0 only", d, 32'h0);
        check("R7 masked outputs", outs(), 32'h0);
        cycle(4'h0, 9'h0, 1'b1, 12'h488, 32'hFFFFFFFF);
        rd(12'h488, d); check("R7 unmask readback", d, 32'h1);
        check("R9 dma errors unmasked", outs(), 32'h7);

        // R11: writes elsewhere change nothing
        cycle(4'h0, 9'h0, 1'b1, 12'h060, 32'hFFFFFFFF);
        cycle(4'h0, 9'h0, 1'b1, 12'h058, 32'hFFFFFFFF);
        rd(12'h480, d); check("R11 dma status kept", d, 32'h0F9);
        rd(12'h484, d); check("R11 dma enable kept", d, 32'h1FD);
        rd(12'h060, d); check("R11 unmapped read", d, 32'h0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule